// File: doc/BRIEF.md
# DRAM Refresh Scheduler with Deferral

This block sits on the controller side of a DRAM interface and decides when auto-refresh commands go out. A programmable interval timer produces one refresh obligation every `cfg_interval` clock cycles. Each obligation is added to an owed-refresh counter. Each refresh that is actually issued subtracts one. Because obligations can pile up, refreshes do not have to fire on a rigid period. They are deferred while access traffic is pending and then issued in a burst. The long-run average still matches the interval, which is what the retention period requires. For example, 8192 rows refreshed within 64 ms gives one command about every 7.8 µs.

Refresh takes priority over traffic only when the owed count reaches the programmed threshold `cfg_debt_max`. Below that threshold, a refresh is started only when the access side is quiet. Before a refresh, the scheduler asks the command sequencer to close all open rows and waits for an acknowledge that also covers the precharge time. It then emits a one-cycle refresh command. Accesses are blocked for the programmed refresh duration. The device needs no row address. The scheduler keeps a mirror of the device's internal row counter, and that mirror is used for checking.

Top module: `rfsh_sched`

## Requirements
- R1: While reset is asserted and in the first cycle after release, `ref_cmd`, `pre_req`, `acc_block`, `debt` and `row_mirror` are all zero.
- R2: With `cfg_interval` ≥ 2 held constant, the owed count rises by one every `cfg_interval` clock edges after reset. After n edges with no refresh issued, it equals floor(n / `cfg_interval`).
- R3: Each `ref_cmd` pulse lowers the owed count by one at the following edge. A tick and an issue at the same edge leave the count unchanged.
- R4: While the scheduler is idle (`acc_block` low), `acc_pending` is high and the owed count is below `cfg_debt_max`, no refresh sequence starts: `pre_req` stays low in the next cycle.
- R5: While idle with the owed count ≥ `cfg_debt_max` and nonzero, `pre_req` goes high in the next cycle regardless of `acc_pending`.
- R6: While idle with `acc_pending` low and the owed count nonzero, `pre_req` goes high in the next cycle. Owed refreshes therefore drain back to back, with one idle cycle between them.
- R7: `pre_req` stays high until `pre_ack` is sampled high. `ref_cmd` is a single-cycle pulse, and it occurs only in the cycle after one in which both `pre_req` and `pre_ack` were high.
- R8: `acc_block` is high in every cycle in which `pre_req` is high. It is also high for exactly `cfg_trfc` cycles (with `cfg_trfc` ≥ 2), starting with the `ref_cmd` cycle. It is low otherwise.
- R9: `row_mirror` advances by one at each `ref_cmd` and wraps from `ROWS`-1 to 0. Its value is always the number of issued refreshes modulo `ROWS`.
- R10: The owed count saturates at 2^`DEBT_W`-1. Further ticks without an issue leave it at that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_interval | input | IVL_W | Cycles between refresh obligations (≥ 2) |
| cfg_trfc | input | RFC_W | Cycles accesses stay blocked from the refresh command (≥ 2) |
| cfg_debt_max | input | DEBT_W | Owed count at which refresh overrides traffic |
| acc_pending | input | 1 | Access traffic is waiting for the bus |
| pre_ack | input | 1 | Sequencer: all rows closed and precharge time met |
| pre_req | output | 1 | Request to the sequencer to precharge all rows |
| ref_cmd | output | 1 | One-cycle auto-refresh command request |
| acc_block | output | 1 | Accesses must be held off |
| debt | output | DEBT_W | Current owed-refresh count |
| row_mirror | output | $clog2(ROWS) | Mirror of the device's refreshed-row counter |

## Verification
The bench builds the block with `ROWS` = 5 and `DEBT_W` = 4. A row count that is not a power of two selects the compare-based wrap variant, and it wraps every five refreshes, so many wraps occur in a short run. A four-bit owed counter saturates at 15 within about 320 cycles when `cfg_interval` is 20. A threshold of 3 and `cfg_trfc` of 4 let the bench cover deferral, forcing, burst draining and block windows within a few hundred cycles. The expected owed count, row mirror and block window are recomputed in the bench each cycle from edge counts and observed pulses.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_PRECH = 2'd1,
      ST_REF   = 2'd2,
      ST_BUSY  = 2'd3
   } rfsh_state_e;

endpackage

// File: rtl/rfsh_tick.sv
module rfsh_tick #(
   parameter int IVL_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IVL_W-1:0] cfg_interval,
   output logic             tick
);

   logic [IVL_W-1:0] cnt;
   logic [IVL_W-1:0] last;

   assign last = cfg_interval - IVL_W'(1);
   assign tick = (cnt >= last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (tick) begin
         cnt <= '0;
      end else begin
         cnt <= cnt + IVL_W'(1);
      end
   end

   // R2: ticks are separated by at least one cycle for legal intervals
   p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && cfg_interval >= IVL_W'(2) && $stable(cfg_interval)) |=> !tick);

endmodule

// File: rtl/rfsh_debt.sv
module rfsh_debt #(
   parameter int DEBT_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              issue,
   output logic [DEBT_W-1:0] debt
);

   localparam logic [DEBT_W-1:0] TOP = {DEBT_W{1'b1}};

   logic [DEBT_W-1:0] debt_nx;

   always_comb begin
      debt_nx = debt;
      unique case ({tick, issue})
         2'b10:   debt_nx = (debt == TOP) ? debt : debt + DEBT_W'(1);
         2'b01:   debt_nx = (debt == '0) ? debt : debt - DEBT_W'(1);
         default: debt_nx = debt;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         debt <= '0;
      end else begin
         debt <= debt_nx;
      end
   end

   // R3: a refresh is only issued while one is owed
   p_issue_owed_r3: assert property (@(posedge clk) disable iff (!rst_n)
      issue |-> (debt != '0));

   // R3: an issue without a tick lowers the count
   p_issue_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && !tick) |=> (debt == $past(debt) - DEBT_W'(1)));

   // R10: no wrap past the saturation value
   p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (debt == TOP && !issue) |=> (debt == TOP));

endmodule

// File: rtl/rfsh_seq.sv
module rfsh_seq
   import rfsh_pkg::*;
#(
   parameter int DEBT_W = 4,
   parameter int RFC_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DEBT_W-1:0] debt,
   input  logic [DEBT_W-1:0] cfg_debt_max,
   input  logic [RFC_W-1:0]  cfg_trfc,
   input  logic              acc_pending,
   input  logic              pre_ack,
   output logic              pre_req,
   output logic              ref_cmd,
   output logic              acc_block
);

   rfsh_state_e      st, st_nx;
   logic [RFC_W-1:0] tmr, tmr_nx;
   logic             owed;
   logic             urgent;
   logic             start;

   assign owed   = (debt != '0);
   assign urgent = owed && (debt >= cfg_debt_max);
   assign start  = owed && (!acc_pending || urgent);

   always_comb begin
      st_nx  = st;
      tmr_nx = tmr;
      unique case (st)
         ST_IDLE: begin
            if (start) st_nx = ST_PRECH;
         end
         ST_PRECH: begin
            if (pre_ack) st_nx = ST_REF;
         end
         ST_REF: begin
            tmr_nx = cfg_trfc - RFC_W'(1);
            st_nx  = (cfg_trfc <= RFC_W'(1)) ? ST_IDLE : ST_BUSY;
         end
         ST_BUSY: begin
            if (tmr <= RFC_W'(1)) begin
               st_nx = ST_IDLE;
            end else begin
               tmr_nx = tmr - RFC_W'(1);
            end
         end
         default: st_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= ST_IDLE;
         tmr <= '0;
      end else begin
         st  <= st_nx;
         tmr <= tmr_nx;
      end
   end

   assign pre_req   = (st == ST_PRECH);
   assign ref_cmd   = (st == ST_REF);
   assign acc_block = (st != ST_IDLE);

   // R4: pending traffic below the threshold defers refresh
   p_defer_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE && acc_pending && !urgent) |=> !pre_req);

   // R5: threshold reached forces the sequence
   p_force_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE && urgent) |=> pre_req);

   // R6: quiet bus with owed refreshes starts the sequence
   p_opportune_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE && !acc_pending && owed) |=> pre_req);

   // R7: command only after a granted precharge
   p_ack_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ref_cmd |-> $past(pre_req && pre_ack));

   // R7: request held until acknowledged
   p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (pre_req && !pre_ack) |=> pre_req);

   // R7: single-cycle command
   p_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ref_cmd |=> !ref_cmd);

   // R8: blocking covers precharge and command cycles
   p_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (pre_req || ref_cmd) |-> acc_block);

endmodule

// File: rtl/rfsh_row.sv
module rfsh_row #(
   parameter int ROWS = 8192
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    inc,
   output logic [$clog2(ROWS)-1:0] row
);

   localparam int ROW_W = $clog2(ROWS);
   localparam logic [ROW_W-1:0] LAST = ROW_W'(ROWS - 1);
   localparam bit POW2 = ((ROWS & (ROWS - 1)) == 0);

   logic [ROW_W-1:0] row_nx;

   generate
      if (POW2) begin : g_pow2
         assign row_nx = row + ROW_W'(1);
      end else begin : g_cmp
         assign row_nx = (row == LAST) ? '0 : row + ROW_W'(1);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         row <= '0;
      end else if (inc) begin
         row <= row_nx;
      end
   end

   // R9: wrap after the last row
   p_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && row == LAST) |=> (row == '0));

   // R9: single step otherwise
   p_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && row != LAST) |=> (row == $past(row) + ROW_W'(1)));

   // R9: value stays inside the row range
   p_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
      row <= LAST);

endmodule

// File: rtl/rfsh_sched.sv
module rfsh_sched #(
   parameter int IVL_W  = 16,
   parameter int RFC_W  = 8,
   parameter int DEBT_W = 4,
   parameter int ROWS   = 8192
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [IVL_W-1:0]        cfg_interval,
   input  logic [RFC_W-1:0]        cfg_trfc,
   input  logic [DEBT_W-1:0]       cfg_debt_max,
   input  logic                    acc_pending,
   input  logic                    pre_ack,
   output logic                    pre_req,
   output logic                    ref_cmd,
   output logic                    acc_block,
   output logic [DEBT_W-1:0]       debt,
   output logic [$clog2(ROWS)-1:0] row_mirror
);

   generate
      if (IVL_W < 2) begin : g_bad_ivl
         $error("IVL_W must be at least 2");
      end
      if (RFC_W < 2) begin : g_bad_rfc
         $error("RFC_W must be at least 2");
      end
      if (DEBT_W < 1) begin : g_bad_debt
         $error("DEBT_W must be at least 1");
      end
      if (ROWS < 2) begin : g_bad_rows
         $error("ROWS must be at least 2");
      end
   endgenerate

   logic tick;

   rfsh_tick #(.IVL_W(IVL_W)) u_tick (
      .clk          (clk),
      .rst_n        (rst_n),
      .cfg_interval (cfg_interval),
      .tick         (tick)
   );

   rfsh_debt #(.DEBT_W(DEBT_W)) u_debt (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick),
      .issue (ref_cmd),
      .debt  (debt)
   );

   rfsh_seq #(.DEBT_W(DEBT_W), .RFC_W(RFC_W)) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .debt         (debt),
      .cfg_debt_max (cfg_debt_max),
      .cfg_trfc     (cfg_trfc),
      .acc_pending  (acc_pending),
      .pre_ack      (pre_ack),
      .pre_req      (pre_req),
      .ref_cmd      (ref_cmd),
      .acc_block    (acc_block)
   );

   rfsh_row #(.ROWS(ROWS)) u_row (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (ref_cmd),
      .row   (row_mirror)
   );

   // R1: quiet outputs right after reset
   p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!ref_cmd && !pre_req && debt == '0));

endmodule

// File: tb/rfsh_sched_bench.sv
module rfsh_sched_bench;

   localparam int IVL_W  = 8;
   localparam int RFC_W  = 8;
   localparam int DEBT_W = 4;
   localparam int ROWS   = 5;
   localparam int ROW_W  = $clog2(ROWS);
   localparam int IVL    = 20;
   localparam int TRFC   = 4;
   localparam int DMAX   = 3;
   localparam int TOP    = (1 << DEBT_W) - 1;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              acc_pending = 1'b0;
   logic              pre_ack = 1'b0;
   logic              pre_req, ref_cmd, acc_block;
   logic [DEBT_W-1:0] debt;
   logic [ROW_W-1:0]  row_mirror;

   int  checks = 0;
   int  errors = 0;
   int  n = 0;
   int  refs = 0;
   int  blk_left = 0;
   int  wc = 0;
   int  cyc = 0;
   bit  ack_en = 1'b1;
   bit  mon_debt_en = 1'b1;
   bit  prev_block = 1'b1;
   bit  prev_pend = 1'b0;
   bit  prev_req = 1'b0;
   bit  prev_ack = 1'b0;
   bit  prev_ref = 1'b0;
   int  prev_debt = 0;

   always #2 clk = ~clk;

   rfsh_sched #(.IVL_W(IVL_W), .RFC_W(RFC_W), .DEBT_W(DEBT_W), .ROWS(ROWS)) u_rfsh_sched (
      .clk          (clk),
      .rst_n        (rst_n),
      .cfg_interval (IVL_W'(IVL)),
      .cfg_trfc     (RFC_W'(TRFC)),
      .cfg_debt_max (DEBT_W'(DMAX)),
      .acc_pending  (acc_pending),
      .pre_ack      (pre_ack),
      .pre_req      (pre_req),
      .ref_cmd      (ref_cmd),
      .acc_block    (acc_block),
      .debt         (debt),
      .row_mirror   (row_mirror)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d (edge %0d)", req, act, exp, n);
      end
   endtask

   // edge counter since reset release
   always @(posedge clk) begin
      if (!rst_n) n = 0;
      else n = n + 1;
   end

   // sequencer model: acknowledge precharge after two cycles
   always @(posedge clk) begin
      #1;
      if (pre_ack) begin
         pre_ack = 1'b0;
         wc = 0;
      end else if (pre_req && ack_en) begin
         wc = wc + 1;
         if (wc >= 2) pre_ack = 1'b1;
      end else begin
         wc = 0;
      end
   end

   // per-cycle monitor
   always @(negedge clk) begin
      if (!rst_n) begin
         prev_block = 1'b1;
         refs = 0;
         blk_left = 0;
      end else begin
         if (mon_debt_en)
            chk(int'(debt) == n / IVL - refs, "R2 R3 owed count", int'(debt), n / IVL - refs);
         chk(int'(row_mirror) == refs % ROWS, "R9 row mirror", int'(row_mirror), refs % ROWS);
         if (ref_cmd) begin
            chk(prev_req && prev_ack && !prev_ref, "R7 command after ack", 0, 1);
            blk_left = TRFC;
         end
         chk(acc_block == (pre_req || blk_left != 0), "R8 block window",
             int'(acc_block), int'(pre_req || blk_left != 0));
         if (blk_left > 0) blk_left = blk_left - 1;
         if (!prev_block) begin
            if (prev_debt >= DMAX)
               chk(pre_req, "R5 forced start", int'(pre_req), 1);
            else if (prev_debt != 0 && !prev_pend)
               chk(pre_req, "R6 idle start", int'(pre_req), 1);
            else
               chk(!pre_req, "R4 deferral", int'(pre_req), 0);
         end
         if (prev_req && !prev_ack)
            chk(pre_req, "R7 request held", int'(pre_req), 1);
         if (ref_cmd) refs = refs + 1;
         prev_block = acc_block;
         prev_pend  = acc_pending;
         prev_req   = pre_req;
         prev_ack   = pre_ack;
         prev_ref   = ref_cmd;
         prev_debt  = int'(debt);
      end
   end

   task automatic do_reset();
      @(posedge clk); #1;
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      // R1: outputs during reset
      chk(!ref_cmd && !pre_req && !acc_block && debt == 0 && row_mirror == 0,
          "R1 reset state", int'({ref_cmd, pre_req, acc_block}), 0);
      @(posedge clk); #1;
      rst_n = 1'b1;
      @(negedge clk);
      chk(!ref_cmd && !pre_req && !acc_block && debt == 0 && row_mirror == 0,
          "R1 after release", int'(debt), 0);
   endtask

   task automatic wait_n(input int k);
      while (n < k) @(negedge clk);
   endtask

   task automatic set_pend(input bit v);
      @(posedge clk); #1;
      acc_pending = v;
   endtask

   initial begin
      // phase A: quiet bus, refreshes go out as soon as owed (R6, R9 wraps)
      ack_en = 1'b1; mon_debt_en = 1'b1;
      do_reset();
      wait_n(IVL);
      @(negedge clk);
      chk(pre_req, "R6 first refresh after one interval", int'(pre_req), 1);
      wait_n(230);
      chk(refs >= 10, "R9 several wraps reached", refs, 10);

      // phase B: busy bus, deferral until threshold then forced (R4, R5)
      acc_pending = 1'b1;
      do_reset();
      wait_n(DMAX * IVL - 1);
      chk(refs == 0 && int'(debt) == DMAX - 1, "R4 nothing issued while deferred", refs, 0);
      wait_n(DMAX * IVL + 2);
      chk(pre_req, "R5 forced at threshold", int'(pre_req), 1);
      wait_n(DMAX * IVL + 12);
      chk(refs == 1 && int'(debt) == DMAX - 1, "R3 one forced refresh", refs, 1);

      // phase C: burst drain when traffic stops (R6)
      do_reset();
      wait_n(42);
      set_pend(1'b0);
      wait_n(79);
      chk(debt == 0 && refs == 3, "R6 owed refreshes drained", refs, 3);

      // phase D: saturation with acknowledge withheld (R10)
      acc_pending = 1'b1;
      ack_en = 1'b0;
      mon_debt_en = 1'b0;
      do_reset();
      wait_n(16 * IVL + 2);
      chk(int'(debt) == TOP, "R10 saturated", int'(debt), TOP);
      wait_n(17 * IVL + 3);
      chk(int'(debt) == TOP && refs == 0, "R10 holds at top", int'(debt), TOP);
      chk(pre_req && acc_block, "R7 request held without ack", int'(pre_req), 1);
      ack_en = 1'b1;
      wait_n(17 * IVL + 10);
      chk(int'(debt) == TOP - 1 && refs == 1, "R3 decrement from top", int'(debt), TOP - 1);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   // watchdog
   always @(posedge clk) begin
      cyc = cyc + 1;
      if (cyc > 20000) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual %0d expected %0d", cyc, 20000);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule